// File: doc/BRIEF.md
# Single-Wire Search Direction Step

This block carries out one bit position of a ROM search on a single-wire bus. On a start strobe it asks the bit-slot engine for two read slots: the first returns the identity bit that every still-selected device drives, and the second returns the complement of that bit. From the two values it decides which branch of the search tree to follow. It then asks for a write slot that carries the chosen direction, so that devices on the other branch drop out.

The caller supplies a preferred direction. This direction is used only when both branches are populated, that is when both read bits are 0. When only one branch is populated, the block overrides the preference and follows the device value. When both read bits are 1, no device answered. The block then stops without a write slot and reports the error code. The result is a 3-bit status that comes with a one-cycle done pulse. The status stays unchanged until the next operation completes.

The bit-slot engine is driven through a request/done handshake. `slot_req` is held high with a stable `slot_kind` and `slot_wbit` until the engine pulses `slot_done`. For reads, the engine returns the sampled level on `slot_rbit` in the same cycle as `slot_done`.

Controller states: IDLE, then RD_ID (first read slot), RD_CMP (second read slot), DECIDE (choose the direction or abort), WR_DIR (write slot with the direction), and FINISH (done pulse), then back to IDLE. The transitions are:
- IDLE goes to RD_ID on start.
- RD_ID goes to RD_CMP on slot_done.
- RD_CMP goes to DECIDE on slot_done.
- DECIDE goes to FINISH when both bits are 1, and to WR_DIR otherwise.
- WR_DIR goes to FINISH on slot_done.
- FINISH goes to IDLE unconditionally.

Top module: `ow_search_step`

## Requirements
- R1: After reset, `done` is 0, `slot_req` is 0 and `status` is 3'b000.
- R2: Each operation issues exactly two read slots (`slot_kind`=0) before any write slot (`slot_kind`=1). The first read supplies the identity bit and the second supplies the complement bit.
- R3: Status bit 0 holds the identity bit, bit 1 holds the complement bit and bit 2 holds the direction taken. Only the codes 000, 100, 101, 010 and 011 occur.
- R4: When both read bits are 1, the status is 3'b011 and no write slot is issued.
- R5: When both read bits are 0, the preferred direction is taken. The status is 3'b100 with write bit 1 when the preference is 1, and 3'b000 with write bit 0 when it is 0.
- R6: When exactly one read bit is 1, the direction equals the identity bit, whatever the preference. The status is 3'b101 with write bit 1 when the identity bit is 1, and 3'b010 with write bit 0 when the complement bit is 1.
- R7: The preferred direction is sampled in the cycle the start is accepted. Later changes of `pref_dir` have no effect on that operation.
- R8: A start strobe raised while an operation is in progress is ignored. It neither restarts nor adds slots.
- R9: `done` is high for exactly one cycle per operation. `status` changes only in the cycle `done` is high and holds its value in every other cycle.
- R10: Once `slot_req` is raised, it stays high with `slot_kind` and `slot_wbit` unchanged until the cycle in which `slot_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start strobe, accepted only when idle |
| pref_dir | input | 1 | Direction to take when both branches exist |
| slot_req | output | 1 | Slot request to the bit-slot engine |
| slot_kind | output | 1 | 0 = read slot, 1 = write slot |
| slot_wbit | output | 1 | Bit to send in a write slot |
| slot_done | input | 1 | Engine pulse: requested slot finished |
| slot_rbit | input | 1 | Level sampled in a read slot, valid with slot_done |
| status | output | 3 | {direction, complement bit, identity bit} |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checker assumes that the engine pulses `slot_done` only while `slot_req` is high, that it pulses it for one cycle per slot, and that `slot_rbit` is meaningful only in that cycle. The bench's engine model meets these assumptions. It waits for a request, holds `slot_done` low for a chosen latency of 0 to 3 cycles, raises it for exactly one cycle, and then waits before looking for the next request. The start strobe is raised for one cycle from idle. Extra starts during an operation are sent on purpose to exercise the rule that such starts are ignored.

// File: rtl/ow_step_pkg.sv
package ow_step_pkg;

    localparam int STATUS_W = 3;
    localparam int POS_ID   = 0;
    localparam int POS_CMP  = 1;
    localparam int POS_DIR  = 2;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_ID  = 3'd1,
        ST_RD_CMP = 3'd2,
        ST_DECIDE = 3'd3,
        ST_WR_DIR = 3'd4,
        ST_FINISH = 3'd5
    } step_state_t;

    typedef enum logic {
        SLOT_READ  = 1'b0,
        SLOT_WRITE = 1'b1
    } slot_kind_t;

endpackage

// File: rtl/ow_step_decide.sv
module ow_step_decide
    import ow_step_pkg::*;
(
    input  logic                id_bit,
    input  logic                cmp_bit,
    input  logic                pref,
    output logic [STATUS_W-1:0] code,
    output logic                dir,
    output logic                abort
);
    always_comb begin
        code  = '0;
        abort = id_bit & cmp_bit;
        if (id_bit == cmp_bit) begin
            // both equal: either nobody answered or both branches exist
            dir = abort ? 1'b0 : pref;
        end else begin
            dir = id_bit;
        end
        code[POS_ID]  = id_bit;
        code[POS_CMP] = cmp_bit;
        code[POS_DIR] = abort ? 1'b0 : dir;
    end
endmodule

// File: rtl/ow_step_sample.sv
module ow_step_sample
    import ow_step_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_pref,
    input  logic                pref_in,
    input  logic                cap_id,
    input  logic                cap_cmp,
    input  logic                rbit,
    input  logic                load_status,
    input  logic [STATUS_W-1:0] status_in,
    output logic                id_q,
    output logic                cmp_q,
    output logic                pref_q,
    output logic [STATUS_W-1:0] status_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q     <= 1'b0;
            cmp_q    <= 1'b0;
            pref_q   <= 1'b0;
            status_q <= '0;
        end else begin
            if (cap_pref)    pref_q   <= pref_in;
            if (cap_id)      id_q     <= rbit;
            if (cap_cmp)     cmp_q    <= rbit;
            if (load_status) status_q <= status_in;
        end
    end
endmodule

// File: rtl/ow_step_ctrl.sv
module ow_step_ctrl
    import ow_step_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        slot_done,
    input  logic        abort,
    output step_state_t state,
    output logic        slot_req,
    output logic        slot_kind,
    output logic        cap_pref,
    output logic        cap_id,
    output logic        cap_cmp,
    output logic        load_status,
    output logic        done
);
    step_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (go)        nxt = ST_RD_ID;
            ST_RD_ID:  if (slot_done) nxt = ST_RD_CMP;
            ST_RD_CMP: if (slot_done) nxt = ST_DECIDE;
            ST_DECIDE: nxt = abort ? ST_FINISH : ST_WR_DIR;
            ST_WR_DIR: if (slot_done) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        slot_req    = 1'b0;
        slot_kind   = SLOT_READ;
        cap_pref    = 1'b0;
        cap_id      = 1'b0;
        cap_cmp     = 1'b0;
        load_status = 1'b0;
        done        = 1'b0;
        unique case (state)
            ST_IDLE:   cap_pref = go;
            ST_RD_ID: begin
                slot_req = 1'b1;
                cap_id   = slot_done;
            end
            ST_RD_CMP: begin
                slot_req = 1'b1;
                cap_cmp  = slot_done;
            end
            ST_DECIDE: load_status = abort;
            ST_WR_DIR: begin
                slot_req    = 1'b1;
                slot_kind   = SLOT_WRITE;
                load_status = slot_done;
            end
            ST_FINISH: done = 1'b1;
            default:   done = 1'b0;
        endcase
    end
endmodule

// File: rtl/ow_search_step.sv
module ow_search_step
    import ow_step_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic                pref_dir,
    output logic                slot_req,
    output logic                slot_kind,
    output logic                slot_wbit,
    input  logic                slot_done,
    input  logic                slot_rbit,
    output logic [STATUS_W-1:0] status,
    output logic                done
);
    step_state_t         state;
    logic                cap_pref, cap_id, cap_cmp, load_status;
    logic                id_q, cmp_q, pref_q;
    logic [STATUS_W-1:0] code;
    logic                dir, abort;

    ow_step_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .slot_done   (slot_done),
        .abort       (abort),
        .state       (state),
        .slot_req    (slot_req),
        .slot_kind   (slot_kind),
        .cap_pref    (cap_pref),
        .cap_id      (cap_id),
        .cap_cmp     (cap_cmp),
        .load_status (load_status),
        .done        (done)
    );

    ow_step_sample sample_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_pref    (cap_pref),
        .pref_in     (pref_dir),
        .cap_id      (cap_id),
        .cap_cmp     (cap_cmp),
        .rbit        (slot_rbit),
        .load_status (load_status),
        .status_in   (code),
        .id_q        (id_q),
        .cmp_q       (cmp_q),
        .pref_q      (pref_q),
        .status_q    (status)
    );

    ow_step_decide decide_i (
        .id_bit  (id_q),
        .cmp_bit (cmp_q),
        .pref    (pref_q),
        .code    (code),
        .dir     (dir),
        .abort   (abort)
    );

    assign slot_wbit = (slot_kind == SLOT_WRITE) ? dir : 1'b0;
endmodule

// File: rtl/ow_search_step_chk.sv
module ow_search_step_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       slot_req,
    input logic       slot_kind,
    input logic       slot_wbit,
    input logic       slot_done,
    input logic [2:0] status,
    input logic       done
);
    logic wr_seen, wr_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen <= 1'b0;
            wr_bit  <= 1'b0;
        end else if (done) begin
            wr_seen <= 1'b0;
        end else if (slot_req && slot_kind && slot_done) begin
            wr_seen <= 1'b1;
            wr_bit  <= slot_wbit;
        end
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_status_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(status));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && !slot_done) |=> (slot_req && $stable(slot_kind) && $stable(slot_wbit)));

    assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status == 3'b000 || status == 3'b100 || status == 3'b101 ||
                  status == 3'b010 || status == 3'b011));

    assert_abort_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 3'b011) |-> !wr_seen);

    assert_write_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 3'b011) |-> (wr_seen && wr_bit == status[2]));
endmodule

bind ow_search_step ow_search_step_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_req  (slot_req),
    .slot_kind (slot_kind),
    .slot_wbit (slot_wbit),
    .slot_done (slot_done),
    .status    (status),
    .done      (done)
);

// File: tb/ow_search_step_tb_top.sv
module ow_search_step_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0;
    logic       pref_dir = 1'b0;
    logic       slot_req, slot_kind, slot_wbit;
    logic       slot_done = 1'b0;
    logic       slot_rbit = 1'b0;
    logic [2:0] status;
    logic       done;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    ow_search_step dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .pref_dir(pref_dir),
        .slot_req(slot_req), .slot_kind(slot_kind), .slot_wbit(slot_wbit),
        .slot_done(slot_done), .slot_rbit(slot_rbit),
        .status(status), .done(done)
    );

    typedef struct {
        logic [2:0] code;
        int         writes;
        logic       wbit;
    } exp_t;

    exp_t exp_q[$];

    // engine scenario and log
    logic eng_id = 1'b0, eng_cmp = 1'b0;
    int   eng_lat = 1;
    int   eng_reads = 0, eng_writes = 0;
    logic eng_wbit = 1'b0;
    logic eng_order_bad = 1'b0;
    int   ops_done = 0;
    logic [2:0] last_status = 3'b000;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // bit-slot engine model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && slot_req) begin
                logic k, wb, held;
                k = slot_kind;
                wb = slot_wbit;
                held = 1'b1;
                for (int i = 0; i < eng_lat; i++) begin
                    @(negedge clk);
                    if (!slot_req || slot_kind != k || slot_wbit != wb) held = 1'b0;
                end
                chk(held, "R10 request held", int'(held), 1);
                if (k == 1'b0) begin
                    slot_rbit = (eng_reads == 0) ? eng_id : eng_cmp;
                    eng_reads++;
                end else begin
                    if (eng_reads < 2) eng_order_bad = 1'b1;
                    eng_writes++;
                    eng_wbit = wb;
                end
                slot_done = 1'b1;
                @(negedge clk);
                slot_done = 1'b0;
                slot_rbit = 1'b0;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        logic prev_done;
        prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (done) begin
                    exp_t e;
                    chk(!prev_done, "R9 single-cycle done", int'(prev_done), 0);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 unexpected done", 1, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(status == e.code, "R4/R5/R6 status code", int'(status), int'(e.code));
                        chk(status[0] == eng_id && status[1] == eng_cmp, "R3 bit layout",
                            int'(status[1:0]), int'({eng_cmp, eng_id}));
                        chk(eng_reads == 2 && !eng_order_bad, "R2 two reads first",
                            eng_reads, 2);
                        chk(eng_writes == e.writes, "R4 write slot count", eng_writes, e.writes);
                        if (e.writes == 1)
                            chk(eng_wbit == e.wbit, "R5/R6 write bit", int'(eng_wbit), int'(e.wbit));
                    end
                    last_status = status;
                    ops_done++;
                end
                prev_done = done;
            end
        end
    end

    task automatic run_op(input logic id, input logic cmp, input logic pref,
                          input int lat, input bit flip_pref, input bit dup_go);
        exp_t e;
        int target;
        if (id && cmp) begin
            e.code = 3'b011; e.writes = 0; e.wbit = 1'b0;
        end else if (!id && !cmp) begin
            e.code = {pref, 2'b00}; e.writes = 1; e.wbit = pref;
        end else begin
            e.code = id ? 3'b101 : 3'b010; e.writes = 1; e.wbit = id;
        end
        exp_q.push_back(e);
        target = ops_done + 1;
        @(negedge clk);
        chk(status == last_status, "R9 status held", int'(status), int'(last_status));
        chk(!slot_req, "R9 idle no request", int'(slot_req), 0);
        eng_id = id; eng_cmp = cmp; eng_lat = lat;
        eng_reads = 0; eng_writes = 0; eng_order_bad = 1'b0;
        go = 1'b1; pref_dir = pref;
        @(negedge clk);
        go = 1'b0;
        if (flip_pref) pref_dir = ~pref;  // R7
        if (dup_go) begin                  // R8
            repeat (2) @(negedge clk);
            go = 1'b1;
            pref_dir = ~pref;
            @(negedge clk);
            go = 1'b0;
        end
        while (ops_done < target) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(ops_done == target, "R8 no extra operation", ops_done, target);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && slot_req == 1'b0 && status == 3'b000, "R1 reset state",
            int'({done, slot_req, status}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && slot_req == 1'b0 && status == 3'b000, "R1 after release",
            int'({done, slot_req, status}), 0);
        run_op(1'b1, 1'b1, 1'b0, 1, 1'b0, 1'b0);  // R4
        run_op(1'b1, 1'b1, 1'b1, 0, 1'b0, 1'b0);  // R4
        run_op(1'b0, 1'b0, 1'b1, 2, 1'b0, 1'b0);  // R5
        run_op(1'b0, 1'b0, 1'b0, 3, 1'b0, 1'b0);  // R5
        run_op(1'b1, 1'b0, 1'b0, 1, 1'b0, 1'b0);  // R6 override
        run_op(1'b0, 1'b1, 1'b1, 2, 1'b0, 1'b0);  // R6 override
        run_op(1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0);  // R6
        run_op(1'b0, 1'b1, 1'b0, 3, 1'b0, 1'b0);  // R6
        run_op(1'b0, 1'b0, 1'b1, 3, 1'b1, 1'b0);  // R7
        run_op(1'b0, 1'b0, 1'b0, 2, 1'b1, 1'b0);  // R7
        run_op(1'b0, 1'b0, 1'b1, 3, 1'b0, 1'b1);  // R8
        run_op(1'b1, 1'b1, 1'b0, 3, 1'b0, 1'b1);  // R8
        chk(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule